// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers 8-bit characters from an asynchronous serial line. A sampling enable, `tick`, pulses at sixteen times the baud rate, so one bit period is sixteen ticks. The line first passes through a two-flop synchronizer. While waiting, the receiver needs a long enough low level before it accepts a start bit, and it throws away shorter dips. After that it reads each data bit, the optional parity bit and the stop bit near the middle of its bit period. It counts from the falling edge it first saw. It does not re-centre on the point where the start bit was confirmed.

Each finished character appears on `data` with a one-cycle `data_valid` pulse. The pulse also updates a parity-error flag and a framing-error flag. A low stop bit gives a framing error, and the receiver then waits for the line to go high again before it looks for a new start. Setting `sync_sel` turns the receiver off, because only the asynchronous mode is built.

Top module: `os_async_rx`

## Requirements
- R1: After reset, `data` is 0x00 and `data_valid`, `par_err` and `frame_err` are all 0.
- R2: Characters arrive least-significant bit first. With index 0 as the first tick that sees the line low, D0 is sampled at tick 24 and each later bit 16 ticks after the one before. `data` then carries the 8-bit value.
- R3: A low level that lasts 7 ticks or fewer is dropped. No strobe follows it, and `data` and the flags keep their values.
- R4: A low level that lasts 8 ticks or more counts as a start bit. An 8-tick dip followed by a high line gives the character 0xFF.
- R5: With `par_en`=1, one parity bit follows D7. With `par_odd`=0 the expected parity bit is the XOR of the 8 data bits; with `par_odd`=1 it is the inverse of that XOR. A mismatch sets `par_err`=1 together with the strobe, and a match clears it.
- R6: With `par_en`=0, the stop bit follows D7 directly and `par_err` is 0 on every strobe.
- R7: A low stop-bit sample sets `frame_err`=1 with the strobe and still delivers `data`. The receiver then stays idle until the line is high again. A line that stays low therefore produces no extra character.
- R8: While `sync_sel`=1 no character is produced.
- R9: `data_valid` is high for exactly one clock, in the cycle after the stop-bit tick. `data`, `par_err` and `frame_err` change only together with that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sampling enable at 16x baud |
| sync_sel | input | 1 | 1 turns the receiver off; 0 selects the asynchronous mode |
| rxd | input | 1 | Serial input line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data | output | 8 | Last character received |
| data_valid | output | 1 | One-cycle strobe when a character completes |
| par_err | output | 1 | Parity mismatch on the last character |
| frame_err | output | 1 | Low stop bit on the last character |

## Verification
Every one of the 256 byte values goes through without parity. This catches bit order, sampling position and shift errors on any data pattern. Low dips of 1 to 8 ticks locate the exact start-acceptance threshold. Frames with parity are sent with correct and with flipped parity bits under both even and odd settings, which shows whether the parity sense and the mismatch flag are right. A held-low stop bit shows whether the receiver waits for the line to recover, and a frame sent with `sync_sel` set shows whether the mode gate works.

// File: rtl/os_async_rx.sv
module os_async_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sync_sel,
  input  logic       rxd,
  input  logic       par_en,
  input  logic       par_odd,
  output logic [7:0] data,
  output logic       data_valid,
  output logic       par_err,
  output logic       frame_err
);

  typedef enum logic [2:0] {IDLE, START, BITS, PARB, STOP, WAITHI} st_t;

  st_t        state;
  logic [1:0] sync;
  logic [4:0] cnt;
  logic [2:0] bitc;
  logic [7:0] sh;
  logic       pbit;

  wire rx_s = sync[1];
  wire mid  = (cnt == 5'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      cnt        <= '0;
      bitc       <= '0;
      sh         <= '0;
      pbit       <= 1'b0;
      data       <= '0;
      data_valid <= 1'b0;
      par_err    <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      if (sync_sel) begin
        state <= IDLE;
      end else if (tick) begin
        case (state)
          IDLE: if (!rx_s) begin
            state <= START;
            cnt   <= '0;
          end
          START: begin
            cnt <= cnt + 5'd1;
            if (cnt < 5'd7 && rx_s) begin
              state <= IDLE;
            end else if (cnt == 5'd23) begin
              sh    <= {rx_s, sh[7:1]};
              bitc  <= 3'd1;
              cnt   <= '0;
              state <= BITS;
            end
          end
          BITS: begin
            cnt <= mid ? 5'd0 : cnt + 5'd1;
            if (mid) begin
              sh   <= {rx_s, sh[7:1]};
              bitc <= bitc + 3'd1;
              if (bitc == 3'd7) state <= par_en ? PARB : STOP;
            end
          end
          PARB: begin
            cnt <= mid ? 5'd0 : cnt + 5'd1;
            if (mid) begin
              pbit  <= rx_s;
              state <= STOP;
            end
          end
          STOP: begin
            cnt <= mid ? 5'd0 : cnt + 5'd1;
            if (mid) begin
              data       <= sh;
              data_valid <= 1'b1;
              frame_err  <= !rx_s;
              par_err    <= par_en && (pbit != ((^sh) ^ par_odd));
              state      <= rx_s ? IDLE : WAITHI;
            end
          end
          WAITHI: if (rx_s) state <= IDLE;
          default: state <= IDLE;
        endcase
      end
    end
  end

endmodule

module os_async_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       sync_sel,
  input logic       par_en,
  input logic [7:0] data,
  input logic       data_valid,
  input logic       par_err,
  input logic       frame_err
);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> ($stable(data) && $stable(par_err) && $stable(frame_err)));

  // R8
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel |=> !data_valid);

  // R9
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(tick));

  // R6
  no_par_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && par_err) |-> $past(par_en));

endmodule

bind os_async_rx os_async_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sync_sel(sync_sel), .par_en(par_en),
  .data(data), .data_valid(data_valid), .par_err(par_err), .frame_err(frame_err)
);

// File: tb/tb_os_async_rx.sv
module tb_os_async_rx;
  logic clk = 0, rst_n = 0, tick = 0, sync_sel = 0, rxd = 1, par_en = 0, par_odd = 0;
  logic [7:0] data;
  logic data_valid, par_err, frame_err;

  int nvec = 0, nfail = 0;
  int got = 0;
  logic [7:0] g_data;
  logic g_pe, g_fe;
  int cyc = 0;

  always #10 clk = ~clk;

  os_async_rx dut (.clk(clk), .rst_n(rst_n), .tick(tick), .sync_sel(sync_sel), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .data(data), .data_valid(data_valid),
    .par_err(par_err), .frame_err(frame_err));

  always @(negedge clk) begin
    cyc++;
    if (data_valid) begin
      got++;
      g_data = data;
      g_pe = par_err;
      g_fe = frame_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rxd = v;
    tick = 0;
    repeat (2) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic slots(input logic v, input int n);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  task automatic frame(input logic [7:0] b, input bit pen, input logic pb, input logic stopv);
    slots(1, 2);
    slots(0, 16);
    for (int i = 0; i < 8; i++) slots(b[i], 16);
    if (pen) slots(pb, 16);
    slots(stopv, 16);
  endtask

  initial begin
    int base;
    logic pb;
    repeat (3) @(negedge clk);
    chk(data == 8'h00 && !data_valid && !par_err && !frame_err, "R1", {data, data_valid, par_err, frame_err}, 0);
    rst_n = 1;
    slots(1, 4);

    // R2 R6: all bytes, no parity
    for (int b = 0; b < 256; b++) begin
      base = got;
      frame(b[7:0], 0, 0, 1);
      chk(got == base + 1, "R2", got - base, 1);
      chk(g_data == b[7:0], "R2", g_data, b);
      chk(!g_pe && !g_fe, "R6", {g_pe, g_fe}, 0);
    end

    // R3: short dips ignored, data held
    for (int l = 1; l <= 7; l++) begin
      base = got;
      slots(0, l);
      slots(1, 40);
      chk(got == base, "R3", got - base, 0);
      chk(data == 8'hFF && !par_err && !frame_err, "R3", data, 8'hFF);
    end

    // R4: 8-tick dip is a start bit -> 0xFF
    base = got;
    slots(0, 8);
    slots(1, 160);
    chk(got == base + 1, "R4", got - base, 1);
    chk(g_data == 8'hFF && !g_fe, "R4", g_data, 8'hFF);

    // R5: parity, both senses, good and flipped
    par_en = 1;
    for (int m = 0; m < 2; m++) begin
      par_odd = m[0];
      for (int k = 0; k < 12; k++) begin
        logic [7:0] v;
        v = 8'(k * 37 + 5);
        pb = (^v) ^ m[0];
        for (int f = 0; f < 2; f++) begin
          base = got;
          frame(v, 1, pb ^ f[0], 1);
          chk(got == base + 1 && g_data == v, "R5", g_data, v);
          chk(g_pe == f[0], "R5", g_pe, f);
          chk(!g_fe, "R5", g_fe, 0);
        end
      end
    end
    par_en = 0;
    par_odd = 0;

    // R7: low stop, held low, then recovery
    base = got;
    frame(8'hA5, 0, 0, 0);
    slots(0, 60);
    slots(1, 4);
    chk(got == base + 1, "R7", got - base, 1);
    chk(g_data == 8'hA5 && g_fe, "R7", {g_data, g_fe}, {8'hA5, 1'b1});
    base = got;
    frame(8'h3C, 0, 0, 1);
    chk(got == base + 1 && g_data == 8'h3C && !g_fe, "R7", g_data, 8'h3C);

    // R8: disabled mode
    sync_sel = 1;
    base = got;
    frame(8'h12, 0, 0, 1);
    slots(1, 4);
    chk(got == base, "R8", got - base, 0);
    chk(data == 8'h3C, "R9", data, 8'h3C);
    sync_sel = 0;
    slots(1, 4);
    base = got;
    frame(8'h81, 0, 0, 1);
    chk(got == base + 1 && g_data == 8'h81, "R8", g_data, 8'h81);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    wait (cyc > 195000);
    nfail++;
    nvec++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule